// File: doc/BRIEF.md
# Two-Level Crossbar Route Controller

This block steers messages between processing elements that hang off small, fast first-level crossbar switches. Those first-level switches are joined through one large second-level switch. The second-level switch changes its connections slowly.

A request carries a source and a destination element ID. The controller splits each ID into a switch index and a port index. It then decides whether the message can stay inside a single first-level switch or must cross the second-level switch. For a crossing, it emits the port selections for all three hops.

The controller keeps a table of which first-level switches the second-level switch currently pairs together. When a crossing needs a pairing that is absent, the controller rewrites the table. Any older pairing held by either endpoint is dropped. The route is then held back for a fixed reconfiguration stall, so that the slow switch is only retuned when traffic actually demands it.

Requests are taken one at a time with a valid/ready handshake. Results appear as a one-cycle route strobe with per-hop select codes.

Top module: `xbarRouteCtl`

## Requirements
- R1: After reset, reqReady is 1, routeValid is 0, and the pairing table is empty, so the first crossing route to any switch pair is a miss.
- R2: An element ID of SW_BITS+PORT_BITS bits is split as follows. The upper SW_BITS bits name the first-level switch. The lower PORT_BITS bits (4 by default) name the port on that switch.
- R3: A request whose source and destination share a switch, but differ in port, is a local route. It yields routeRemote=0. srcSwSel is the switch, srcInSel is the source port and srcOutSel is the destination port. The global and destination fields are zero. routeValid is high on the second falling edge after the accepting rising edge.
- R4: A request between different switches is a crossing route with routeRemote=1. srcSwSel and srcInSel come from the source. srcOutSel and dstInSel both carry the uplink code 2**PORT_BITS (16 by default). gblInSel is the source switch and gblOutSel is the destination switch. dstSwSel is the destination switch and dstOutSel is the destination port.
- R5: A crossing route whose switch pair is already in the table has routeMiss=0 and the same latency as a local route. A pairing serves both directions.
- R6: A crossing route whose pair is absent has routeMiss=1. It is delayed by exactly STALL_CYC extra cycles (default 64). It installs the pairing for both directions.
- R7: Installing a pairing drops any earlier pairing held by either of its two switches. A later route over a dropped pair is a miss.
- R8: A request with destination equal to source yields routeErr=1 with routeRemote=0, routeMiss=0 and all selects zero. It has the local latency and leaves the table unchanged.
- R9: reqReady is low from the accepting edge until routeValid has been shown. routeValid lasts exactly one cycle, and reqReady is back high on the cycle after it.
- R10: While routeValid is low, every select output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqSrc | input | SW_BITS+PORT_BITS | Source element ID |
| reqDst | input | SW_BITS+PORT_BITS | Destination element ID |
| routeValid | output | 1 | One-cycle strobe: route result valid |
| routeErr | output | 1 | Request rejected (source equals destination) |
| routeRemote | output | 1 | Route crosses the second-level switch |
| routeMiss | output | 1 | Route required a second-level reconfiguration |
| srcSwSel | output | SW_BITS | Switch used by the first hop |
| srcInSel | output | PORT_BITS+1 | Input port of the first hop |
| srcOutSel | output | PORT_BITS+1 | Output port of the first hop |
| gblInSel | output | SW_BITS | Second-level input (source switch) |
| gblOutSel | output | SW_BITS | Second-level output (destination switch) |
| dstSwSel | output | SW_BITS | Switch used by the last hop |
| dstInSel | output | PORT_BITS+1 | Input port of the last hop |
| dstOutSel | output | PORT_BITS+1 | Output port of the last hop |

## Verification
The bench targets the pairing table's replacement behaviour.

A chain of crossings reuses one switch with a new partner, and then returns to the dropped partner. A table that forgot to break the stale pairing would report a hit there and skip the stall. A table that stored only one direction would miss on a reverse route that should hit.

Latency is counted to the exact cycle, so an off-by-one stall counter shows up as 65 or 67 cycles instead of 66.

Self-addressed requests sit between an install and its reuse. An error path that touched the table would turn the following hit into a miss.

Extreme IDs (top switch, top port, switch zero) check that the ID split does not truncate or swap bits.

// File: rtl/xrc_pkg.sv
package xrc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_STALL,
    ST_DONE
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // capture request IDs
    logic commitLink;  // install pairing srcSw<->dstSw
    logic emit;        // route result being presented
    logic remote;      // result is a three-hop route
    logic err;         // result is a rejection
  } ctlStrobe_t;

endpackage

// File: rtl/xrcDatapath.sv
module xrcDatapath
  import xrc_pkg::*;
#(
  parameter int SW_BITS   = 3,
  parameter int PORT_BITS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [SW_BITS+PORT_BITS-1:0]   reqSrc,
  input  logic [SW_BITS+PORT_BITS-1:0]   reqDst,
  input  ctlStrobe_t                     strobe,
  output logic                           isSelf,
  output logic                           isLocal,
  output logic                           linkHit,
  output logic [SW_BITS-1:0]             srcSwSel,
  output logic [PORT_BITS:0]             srcInSel,
  output logic [PORT_BITS:0]             srcOutSel,
  output logic [SW_BITS-1:0]             gblInSel,
  output logic [SW_BITS-1:0]             gblOutSel,
  output logic [SW_BITS-1:0]             dstSwSel,
  output logic [PORT_BITS:0]             dstInSel,
  output logic [PORT_BITS:0]             dstOutSel
);

  localparam int IDW    = SW_BITS + PORT_BITS;
  localparam int NUM_SW = 1 << SW_BITS;
  localparam int PCW    = PORT_BITS + 1;
  localparam logic [PCW-1:0] UPLINK = PCW'(1 << PORT_BITS);

  logic [IDW-1:0] srcR, dstR;
  logic [SW_BITS-1:0]   srcSw, dstSw;
  logic [PORT_BITS-1:0] srcPort, dstPort;

  logic [SW_BITS-1:0] partner [NUM_SW];
  logic [NUM_SW-1:0]  linked;

  assign srcSw   = srcR[IDW-1:PORT_BITS];
  assign dstSw   = dstR[IDW-1:PORT_BITS];
  assign srcPort = srcR[PORT_BITS-1:0];
  assign dstPort = dstR[PORT_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcR <= '0;
      dstR <= '0;
    end else if (strobe.loadReq) begin
      srcR <= reqSrc;
      dstR <= reqDst;
    end
  end

  // pairing table: symmetric, one partner per switch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linked <= '0;
      for (int i = 0; i < NUM_SW; i++) partner[i] <= '0;
    end else if (strobe.commitLink) begin
      for (int i = 0; i < NUM_SW; i++) begin
        if (SW_BITS'(i) == srcSw) begin
          linked[i]  <= 1'b1;
          partner[i] <= dstSw;
        end else if (SW_BITS'(i) == dstSw) begin
          linked[i]  <= 1'b1;
          partner[i] <= srcSw;
        end else if (linked[i] && (partner[i] == srcSw || partner[i] == dstSw)) begin
          linked[i] <= 1'b0;
        end
      end
    end
  end

  assign isSelf  = (srcR == dstR);
  assign isLocal = (srcSw == dstSw);
  assign linkHit = linked[srcSw] && (partner[srcSw] == dstSw);

  logic showAny, showRem;
  assign showAny = strobe.emit && !strobe.err;
  assign showRem = showAny && strobe.remote;

  always_comb begin
    srcSwSel  = showAny ? srcSw : '0;
    srcInSel  = showAny ? {1'b0, srcPort} : '0;
    srcOutSel = showAny ? (strobe.remote ? UPLINK : {1'b0, dstPort}) : '0;
    gblInSel  = showRem ? srcSw : '0;
    gblOutSel = showRem ? dstSw : '0;
    dstSwSel  = showRem ? dstSw : '0;
    dstInSel  = showRem ? UPLINK : '0;
    dstOutSel = showRem ? {1'b0, dstPort} : '0;
  end

endmodule

// File: rtl/xrcCtrl.sv
module xrcCtrl
  import xrc_pkg::*;
#(
  parameter int STALL_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       isSelf,
  input  logic       isLocal,
  input  logic       linkHit,
  output logic       reqReady,
  output ctlStrobe_t strobe,
  output logic       routeValid,
  output logic       routeErr,
  output logic       routeRemote,
  output logic       routeMiss
);

  localparam int CNT_W = (STALL_CYC < 2) ? 1 : $clog2(STALL_CYC);

  ctlState_t  state;
  logic [CNT_W-1:0] stallCnt;
  logic remoteR, errR, missR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stallCnt <= '0;
      remoteR  <= 1'b0;
      errR     <= 1'b0;
      missR    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) state <= ST_CHECK;
        ST_CHECK: begin
          if (isSelf) begin
            errR <= 1'b1; remoteR <= 1'b0; missR <= 1'b0;
            state <= ST_DONE;
          end else if (isLocal) begin
            errR <= 1'b0; remoteR <= 1'b0; missR <= 1'b0;
            state <= ST_DONE;
          end else if (linkHit) begin
            errR <= 1'b0; remoteR <= 1'b1; missR <= 1'b0;
            state <= ST_DONE;
          end else begin
            errR <= 1'b0; remoteR <= 1'b1; missR <= 1'b1;
            stallCnt <= CNT_W'(STALL_CYC - 1);
            state <= ST_STALL;
          end
        end
        ST_STALL: begin
          if (stallCnt == '0) state <= ST_DONE;
          else stallCnt <= stallCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady          = (state == ST_IDLE);
    routeValid        = (state == ST_DONE);
    strobe.loadReq    = reqReady && reqValid;
    strobe.commitLink = (state == ST_CHECK) && !isSelf && !isLocal && !linkHit;
    strobe.emit       = routeValid;
    strobe.remote     = remoteR;
    strobe.err        = errR;
    routeErr          = routeValid && errR;
    routeRemote       = routeValid && remoteR;
    routeMiss         = routeValid && missR;
  end

endmodule

// File: rtl/xbarRouteCtl.sv
module xbarRouteCtl
  import xrc_pkg::*;
#(
  parameter int SW_BITS   = 3,
  parameter int PORT_BITS = 4,
  parameter int STALL_CYC = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [SW_BITS+PORT_BITS-1:0] reqSrc,
  input  logic [SW_BITS+PORT_BITS-1:0] reqDst,
  output logic                         routeValid,
  output logic                         routeErr,
  output logic                         routeRemote,
  output logic                         routeMiss,
  output logic [SW_BITS-1:0]           srcSwSel,
  output logic [PORT_BITS:0]           srcInSel,
  output logic [PORT_BITS:0]           srcOutSel,
  output logic [SW_BITS-1:0]           gblInSel,
  output logic [SW_BITS-1:0]           gblOutSel,
  output logic [SW_BITS-1:0]           dstSwSel,
  output logic [PORT_BITS:0]           dstInSel,
  output logic [PORT_BITS:0]           dstOutSel
);

  ctlStrobe_t strobe;
  logic isSelf, isLocal, linkHit;

  xrcCtrl #(.STALL_CYC(STALL_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .isSelf(isSelf), .isLocal(isLocal), .linkHit(linkHit),
    .reqReady(reqReady), .strobe(strobe),
    .routeValid(routeValid), .routeErr(routeErr),
    .routeRemote(routeRemote), .routeMiss(routeMiss)
  );

  xrcDatapath #(.SW_BITS(SW_BITS), .PORT_BITS(PORT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .reqSrc(reqSrc), .reqDst(reqDst),
    .strobe(strobe), .isSelf(isSelf), .isLocal(isLocal), .linkHit(linkHit),
    .srcSwSel(srcSwSel), .srcInSel(srcInSel), .srcOutSel(srcOutSel),
    .gblInSel(gblInSel), .gblOutSel(gblOutSel), .dstSwSel(dstSwSel),
    .dstInSel(dstInSel), .dstOutSel(dstOutSel)
  );

endmodule

// File: rtl/xbarRouteCtl_chk.sv
module xbarRouteCtl_chk #(
  parameter int SW_BITS   = 3,
  parameter int PORT_BITS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 routeValid,
  input logic                 routeErr,
  input logic                 routeRemote,
  input logic                 routeMiss,
  input logic [SW_BITS-1:0]   srcSwSel,
  input logic [PORT_BITS:0]   srcInSel,
  input logic [PORT_BITS:0]   srcOutSel,
  input logic [SW_BITS-1:0]   gblInSel,
  input logic [SW_BITS-1:0]   gblOutSel,
  input logic [SW_BITS-1:0]   dstSwSel,
  input logic [PORT_BITS:0]   dstInSel,
  input logic [PORT_BITS:0]   dstOutSel
);

  localparam logic [PORT_BITS:0] UPLINK = (PORT_BITS+1)'(1 << PORT_BITS);

  // R9
  route_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    routeValid |=> !routeValid);

  // R9
  busy_while_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    routeValid |-> !reqReady);

  // R9
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10
  idle_selects_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !routeValid |-> (srcSwSel == '0 && srcInSel == '0 && srcOutSel == '0 &&
                     gblInSel == '0 && gblOutSel == '0 && dstSwSel == '0 &&
                     dstInSel == '0 && dstOutSel == '0));

  // R8
  err_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    routeErr |-> (routeValid && !routeMiss && !routeRemote && srcOutSel == '0));

  // R6
  miss_is_remote_chk: assert property (@(posedge clk) disable iff (!rstN)
    routeMiss |-> routeRemote);

  // R4
  remote_uplink_chk: assert property (@(posedge clk) disable iff (!rstN)
    routeRemote |-> (srcOutSel == UPLINK && dstInSel == UPLINK &&
                     gblInSel != gblOutSel && gblInSel == srcSwSel));

endmodule

bind xbarRouteCtl xbarRouteCtl_chk #(.SW_BITS(SW_BITS), .PORT_BITS(PORT_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .routeValid(routeValid), .routeErr(routeErr), .routeRemote(routeRemote),
  .routeMiss(routeMiss), .srcSwSel(srcSwSel), .srcInSel(srcInSel),
  .srcOutSel(srcOutSel), .gblInSel(gblInSel), .gblOutSel(gblOutSel),
  .dstSwSel(dstSwSel), .dstInSel(dstInSel), .dstOutSel(dstOutSel)
);

// File: tb/xbarRouteCtl_bench.sv
`timescale 1ns/1ps
module xbarRouteCtl_bench;

  localparam int SWB = 3;
  localparam int PB  = 4;
  localparam int STALL = 64;
  localparam int IDW = SWB + PB;
  localparam int NSW = 1 << SWB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [IDW-1:0] reqSrc = '0, reqDst = '0;
  logic reqReady, routeValid, routeErr, routeRemote, routeMiss;
  logic [SWB-1:0] srcSwSel, gblInSel, gblOutSel, dstSwSel;
  logic [PB:0] srcInSel, srcOutSel, dstInSel, dstOutSel;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // bench model of the pairing table
  int mPartner [NSW];
  bit mLinked  [NSW];

  always #2.5 clk = ~clk;

  xbarRouteCtl #(.SW_BITS(SWB), .PORT_BITS(PB), .STALL_CYC(STALL)) u_xbarRouteCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSrc(reqSrc), .reqDst(reqDst), .routeValid(routeValid),
    .routeErr(routeErr), .routeRemote(routeRemote), .routeMiss(routeMiss),
    .srcSwSel(srcSwSel), .srcInSel(srcInSel), .srcOutSel(srcOutSel),
    .gblInSel(gblInSel), .gblOutSel(gblOutSel), .dstSwSel(dstSwSel),
    .dstInSel(dstInSel), .dstOutSel(dstOutSel)
  );

  function automatic logic [31:0] selVec();
    return {srcSwSel, srcInSel, srcOutSel, gblInSel, gblOutSel, dstSwSel, dstInSel, dstOutSel};
  endfunction

  function automatic logic [31:0] expVec(int s, int d, bit rem, bit err);
    logic [SWB-1:0] ss, ds;
    logic [PB:0] sp, dp, up;
    ss = SWB'(s >> PB); ds = SWB'(d >> PB);
    sp = (PB+1)'(s % (1 << PB)); dp = (PB+1)'(d % (1 << PB));
    up = (PB+1)'(1 << PB);
    if (err) return '0;
    if (!rem) return {ss, sp, dp, 3'd0, 3'd0, 3'd0, 5'd0, 5'd0};
    return {ss, sp, up, ss, ds, ds, up, dp};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic doReq(int s, int d, string tag);
    bit self, loc, hit, rem, miss;
    int ss, ds, expLat, n;
    ss = s >> PB; ds = d >> PB;   // R2 switch = upper bits
    self = (s == d);
    loc  = (ss == ds);
    hit  = mLinked[ss] && (mPartner[ss] == ds);
    rem  = !self && !loc;
    miss = rem && !hit;
    expLat = miss ? 2 + STALL : 2;
    if (miss) begin
      for (int i = 0; i < NSW; i++) begin
        if (i == ss) begin mLinked[i] = 1; mPartner[i] = ds; end
        else if (i == ds) begin mLinked[i] = 1; mPartner[i] = ss; end
        else if (mLinked[i] && (mPartner[i] == ss || mPartner[i] == ds)) mLinked[i] = 0;
      end
    end
    @(negedge clk);
    reqValid = 1'b1; reqSrc = IDW'(s); reqDst = IDW'(d);
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    chk(!reqReady && !routeValid, "R9", {tag, " busy after accept"}, reqReady, 0);
    chk(selVec() == '0, "R10", {tag, " selects idle"}, selVec(), 0);
    while (!routeValid && n < 400) begin @(negedge clk); n++; end
    chk(n == expLat, miss ? "R6" : "R5", {tag, " latency"}, n, expLat);
    chk(routeErr == self, "R8", {tag, " err flag"}, routeErr, self);
    chk(routeRemote == rem, "R3", {tag, " remote flag"}, routeRemote, rem);
    chk(routeMiss == miss, "R7", {tag, " miss flag"}, routeMiss, miss);
    chk(selVec() == expVec(s, d, rem, self), rem ? "R4" : "R3", {tag, " selects"},
        selVec(), expVec(s, d, rem, self));
    @(negedge clk);
    chk(!routeValid && reqReady, "R9", {tag, " pulse end"}, {routeValid, reqReady}, 1);
  endtask

  function automatic int id(int sw, int p);
    return sw * (1 << PB) + p;
  endfunction

  initial begin
    void'($urandom(32'd7301));
    for (int i = 0; i < NSW; i++) begin mLinked[i] = 0; mPartner[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(reqReady && !routeValid, "R1", "reset state", {reqReady, routeValid}, 2);
    chk(selVec() == '0, "R10", "reset selects", selVec(), 0);

    doReq(id(2, 3), id(2, 9), "R3 local");
    doReq(id(1, 4), id(5, 7), "R1 first crossing miss");
    doReq(id(1, 0), id(5, 2), "R5 hit");
    doReq(id(5, 8), id(1, 1), "R5 reverse hit");
    doReq(id(1, 6), id(1, 6), "R8 self");
    doReq(id(1, 2), id(5, 3), "R8 table kept");
    doReq(id(1, 2), id(6, 3), "R7 steal 1");
    doReq(id(5, 2), id(1, 3), "R7 dropped pair");
    doReq(id(6, 1), id(1, 1), "R7 dropped other");
    doReq(id(7, 15), id(0, 0), "R2 extreme ids");
    doReq(id(0, 15), id(7, 0), "R2 extreme reverse");
    doReq(id(7, 0), id(7, 15), "R2 local extreme");

    for (int k = 0; k < 40; k++) begin
      int s, d;
      s = id($urandom % 4, $urandom % 16);
      d = ($urandom % 8 == 0) ? s : id($urandom % 4, $urandom % 16);
      doReq(s, d, "R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule